// File: doc/BRIEF.md
# CPU Low-Power Halt and Sleep Sequencer

This block sits beside a small 8-bit CPU core and manages its two low-power waits. The instruction decoder sends a one-cycle pulse when a halt or a sleep instruction executes. The block then chooses the wait state and gates the clock enables for the core and the DMA engines. It also stops DRAM refresh requests, drives the active-low halt status pin, and parks the address and control outputs in their idle (all ones) pattern while the bus belongs to the CPU.

While the block waits, it watches the wake-up sources:

- reset;
- NMI;
- a set of external interrupt lines, each with its own enable bit;
- a set of on-chip interrupt requests, each with its own enable bit.

On exit it emits one of two one-cycle pulses. The take-interrupt pulse tells the sequencer to run an interrupt acknowledge, with the return address at the instruction after the wait instruction. The resume pulse tells it to carry on with the next instruction and skip the acknowledge.

The state machine has five states: RUN, HALT, SLEEP, WAKE_IRQ and WAKE_RESUME. Its transitions are:

- RUN to SLEEP on a sleep pulse with all three qualifying bits clear.
- RUN to HALT on a halt pulse. This also covers a halt pulse that arrives together with a disqualified sleep pulse.
- HALT to WAKE_IRQ on NMI, or on an enabled request while the global interrupt enable is set.
- SLEEP to WAKE_IRQ on NMI, or on an enabled request with the global enable set.
- SLEEP to WAKE_RESUME on an enabled request with the global enable clear.
- WAKE_IRQ to RUN and WAKE_RESUME to RUN, always, after one cycle.
- Any state to RUN, asynchronously, on reset.

Top module: `cpu_lowpower_seq`

## Requirements
- R1: While rst_n is low the block is in RUN, in the same cycle and whatever state it was in. In RUN, cpu_clk_en, dma_clk_en, refresh_en and halt_n are 1, both pulses are 0, and the bus outputs copy the core's values.
- R2: A sleep_exec pulse in RUN with io_stop, ctl_stop_a and ctl_stop_b all 0 enters SLEEP from the next cycle. In SLEEP, cpu_clk_en, dma_clk_en, refresh_en and halt_n are all 0.
- R3: A sleep_exec pulse in RUN with any of io_stop, ctl_stop_a or ctl_stop_b set is a no-op. The block stays in RUN and gives no pulse.
- R4: A halt_exec pulse in RUN enters HALT. In HALT, halt_n is 0 and cpu_clk_en, dma_clk_en and refresh_en stay 1. A qualified sleep_exec takes precedence over a simultaneous halt_exec.
- R5: In SLEEP with bus_grant at 0, addr_out and ctl_out are all ones. In SLEEP with bus_grant at 1, and in every other state, they copy core_addr and core_ctl.
- R6: A request on ext_irq or onchip_irq whose matching enable bit is 0 causes no exit from SLEEP or HALT.
- R7: In SLEEP, an enabled request (external or on-chip) with gie at 1 gives one cycle in WAKE_IRQ. In that cycle take_irq_pulse is 1, the clock enables and refresh_en are 1, and halt_n is 1.
- R8: In SLEEP, an enabled request with gie at 0 gives one cycle in WAKE_RESUME. In that cycle resume_pulse is 1 and take_irq_pulse is 0.
- R9: nmi_req leads to WAKE_IRQ from SLEEP or HALT, whatever gie and the enable bits are.
- R10: HALT is left only through WAKE_IRQ. An enabled request with gie at 0 keeps the block in HALT, and one with gie at 1 takes the interrupt.
- R11: The two exit pulses last one cycle each, are never high together, and are followed by RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset, also a wake-up source |
| halt_exec | input | 1 | One-cycle pulse: halt instruction executed |
| sleep_exec | input | 1 | One-cycle pulse: sleep instruction executed |
| io_stop | input | 1 | I/O-stop control bit; when set, sleep is not entered |
| ctl_stop_a | input | 1 | First CPU-control mode bit; when set, sleep is not entered |
| ctl_stop_b | input | 1 | Second CPU-control mode bit; when set, sleep is not entered |
| gie | input | 1 | Global interrupt enable flag |
| nmi_req | input | 1 | Non-maskable interrupt request, active high |
| ext_irq | input | NUM_EXT | External interrupt requests, active high |
| ext_irq_en | input | NUM_EXT | Per-line enables for ext_irq |
| onchip_irq | input | NUM_CHIP | On-chip interrupt requests |
| onchip_irq_en | input | NUM_CHIP | Per-source enables for onchip_irq |
| bus_grant | input | 1 | Bus granted to an external master |
| core_addr | input | ADDR_W | Address from the core |
| core_ctl | input | CTL_W | Control strobes from the core (HALT excluded) |
| addr_out | output | ADDR_W | Address to the pins |
| ctl_out | output | CTL_W | Control strobes to the pins |
| cpu_clk_en | output | 1 | Clock enable for the CPU core |
| dma_clk_en | output | 1 | Clock enable for the DMA channels |
| refresh_en | output | 1 | DRAM refresh request enable |
| halt_n | output | 1 | Halt status, low in HALT and SLEEP |
| resume_pulse | output | 1 | One cycle: continue with the next instruction |
| take_irq_pulse | output | 1 | One cycle: run the interrupt acknowledge |

## Verification
The bench goes after the gie split on the sleep exit. A design that ignored gie would take an interrupt the software had masked, or would leave the CPU resuming when it should vector. It probes each of the three sleep qualifier bits on its own, which catches a design that tests only one of them and so enters sleep in another power mode. It drives requests whose enable bits are clear, in both sleep and halt, which catches a design that wakes on raw requests. It also checks that halt does not exit on an enabled request with gie clear, that reset in the middle of sleep releases every gate in the same cycle, and that the idle bus pattern gives way at once when an external master is granted.

// File: rtl/lowpower_pkg.sv
package lowpower_pkg;

    typedef enum logic [2:0] {
        ST_RUN         = 3'd0,
        ST_HALT        = 3'd1,
        ST_SLEEP       = 3'd2,
        ST_WAKE_IRQ    = 3'd3,
        ST_WAKE_RESUME = 3'd4
    } lp_state_e;

endpackage

// File: rtl/lp_wake_qual.sv
module lp_wake_qual #(
    parameter int NUM_EXT  = 3,
    parameter int NUM_CHIP = 8
) (
    input  logic                nmi_req,
    input  logic [NUM_EXT-1:0]  ext_irq,
    input  logic [NUM_EXT-1:0]  ext_irq_en,
    input  logic [NUM_CHIP-1:0] onchip_irq,
    input  logic [NUM_CHIP-1:0] onchip_irq_en,
    output logic                nmi_wake,
    output logic                masked_wake
);
    logic [NUM_EXT-1:0]  ext_hit;
    logic [NUM_CHIP-1:0] chip_hit;

    // each source counts only when its own enable bit is set
    for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
        assign ext_hit[i] = ext_irq[i] & ext_irq_en[i];
    end

    for (genvar j = 0; j < NUM_CHIP; j++) begin : g_chip
        assign chip_hit[j] = onchip_irq[j] & onchip_irq_en[j];
    end

    assign nmi_wake    = nmi_req;
    assign masked_wake = (|ext_hit) | (|chip_hit);

endmodule

// File: rtl/lp_bus_hold.sv
module lp_bus_hold #(
    parameter int ADDR_W = 20,
    parameter int CTL_W  = 6
) (
    input  logic              park,
    input  logic              bus_grant,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [CTL_W-1:0]  core_ctl,
    output logic [ADDR_W-1:0] addr_out,
    output logic [CTL_W-1:0]  ctl_out
);
    localparam logic [ADDR_W-1:0] ADDR_IDLE = {ADDR_W{1'b1}};
    localparam logic [CTL_W-1:0]  CTL_IDLE  = {CTL_W{1'b1}};

    logic force_idle;

    // an external master that owns the bus keeps its own values
    assign force_idle = park & ~bus_grant;

    always_comb begin
        addr_out = force_idle ? ADDR_IDLE : core_addr;
        ctl_out  = force_idle ? CTL_IDLE  : core_ctl;
    end

endmodule

// File: rtl/cpu_lowpower_seq.sv
module cpu_lowpower_seq
    import lowpower_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int CTL_W    = 6,
    parameter int NUM_EXT  = 3,
    parameter int NUM_CHIP = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                halt_exec,
    input  logic                sleep_exec,
    input  logic                io_stop,
    input  logic                ctl_stop_a,
    input  logic                ctl_stop_b,
    input  logic                gie,
    input  logic                nmi_req,
    input  logic [NUM_EXT-1:0]  ext_irq,
    input  logic [NUM_EXT-1:0]  ext_irq_en,
    input  logic [NUM_CHIP-1:0] onchip_irq,
    input  logic [NUM_CHIP-1:0] onchip_irq_en,
    input  logic                bus_grant,
    input  logic [ADDR_W-1:0]   core_addr,
    input  logic [CTL_W-1:0]    core_ctl,
    output logic [ADDR_W-1:0]   addr_out,
    output logic [CTL_W-1:0]    ctl_out,
    output logic                cpu_clk_en,
    output logic                dma_clk_en,
    output logic                refresh_en,
    output logic                halt_n,
    output logic                resume_pulse,
    output logic                take_irq_pulse
);
    lp_state_e state, state_nx;
    logic      nmi_wake, masked_wake;
    logic      sleep_ok;
    logic      park;

    assign sleep_ok = ~(io_stop | ctl_stop_a | ctl_stop_b);

    lp_wake_qual #(
        .NUM_EXT (NUM_EXT),
        .NUM_CHIP(NUM_CHIP)
    ) u_wake (
        .nmi_req      (nmi_req),
        .ext_irq      (ext_irq),
        .ext_irq_en   (ext_irq_en),
        .onchip_irq   (onchip_irq),
        .onchip_irq_en(onchip_irq_en),
        .nmi_wake     (nmi_wake),
        .masked_wake  (masked_wake)
    );

    // state register; reset is asynchronous so gates release at once
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (sleep_exec && sleep_ok) state_nx = ST_SLEEP;
                else if (halt_exec)         state_nx = ST_HALT;
            end
            ST_HALT: begin
                if (nmi_wake || (masked_wake && gie)) state_nx = ST_WAKE_IRQ;
            end
            ST_SLEEP: begin
                if (nmi_wake || (masked_wake && gie)) state_nx = ST_WAKE_IRQ;
                else if (masked_wake)                  state_nx = ST_WAKE_RESUME;
            end
            ST_WAKE_IRQ:    state_nx = ST_RUN;
            ST_WAKE_RESUME: state_nx = ST_RUN;
            default:        state_nx = ST_RUN;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        cpu_clk_en     = 1'b1;
        dma_clk_en     = 1'b1;
        refresh_en     = 1'b1;
        halt_n         = 1'b1;
        resume_pulse   = 1'b0;
        take_irq_pulse = 1'b0;
        park           = 1'b0;
        unique case (state)
            ST_RUN: ;
            ST_HALT: halt_n = 1'b0;
            ST_SLEEP: begin
                cpu_clk_en = 1'b0;
                dma_clk_en = 1'b0;
                refresh_en = 1'b0;
                halt_n     = 1'b0;
                park       = 1'b1;
            end
            ST_WAKE_IRQ:    take_irq_pulse = 1'b1;
            ST_WAKE_RESUME: resume_pulse   = 1'b1;
            default: ;
        endcase
    end

    lp_bus_hold #(
        .ADDR_W(ADDR_W),
        .CTL_W (CTL_W)
    ) u_bus (
        .park     (park),
        .bus_grant(bus_grant),
        .core_addr(core_addr),
        .core_ctl (core_ctl),
        .addr_out (addr_out),
        .ctl_out  (ctl_out)
    );

    // ---------------- assertions ----------------
    a_r2_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sleep_exec && sleep_ok) |=> (!cpu_clk_en && !dma_clk_en && !halt_n));

    a_r3_sleep_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sleep_exec && !sleep_ok && !halt_exec) |=> (cpu_clk_en && halt_n));

    a_r5_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!refresh_en && !bus_grant) |-> ((&addr_out) && (&ctl_out)));

    a_r6_disabled_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_n && !nmi_req && ((ext_irq & ext_irq_en) == '0) && ((onchip_irq & onchip_irq_en) == '0))
        |=> (!resume_pulse && !take_irq_pulse && !halt_n));

    a_r8_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && masked_wake && !gie && !nmi_wake) |=> resume_pulse);

    a_r10_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !nmi_wake && !gie) |=> !halt_n);

    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(resume_pulse && take_irq_pulse));

    a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_pulse || take_irq_pulse) |=> (!resume_pulse && !take_irq_pulse && halt_n));

endmodule

// File: tb/cpu_lowpower_seq_tb.sv
module cpu_lowpower_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;
    localparam int CW = 6;
    localparam int NE = 3;
    localparam int NC = 8;

    // status vector: {cpu_clk_en, dma_clk_en, refresh_en, halt_n, resume, take_irq}
    localparam logic [5:0] V_RUN = 6'b111100;
    localparam logic [5:0] V_SLP = 6'b000000;
    localparam logic [5:0] V_HLT = 6'b111000;
    localparam logic [5:0] V_RES = 6'b111110;
    localparam logic [5:0] V_IRQ = 6'b111101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_exec = 1'b0, sleep_exec = 1'b0;
    logic io_stop = 1'b0, ctl_stop_a = 1'b0, ctl_stop_b = 1'b0;
    logic gie = 1'b0, nmi_req = 1'b0, bus_grant = 1'b0;
    logic [NE-1:0] ext_irq = '0, ext_irq_en = '0;
    logic [NC-1:0] onchip_irq = '0, onchip_irq_en = '0;
    logic [AW-1:0] core_addr = 20'h1A5C3;
    logic [CW-1:0] core_ctl = 6'b010110;
    logic [AW-1:0] addr_out;
    logic [CW-1:0] ctl_out;
    logic cpu_clk_en, dma_clk_en, refresh_en, halt_n, resume_pulse, take_irq_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string      tag;
        logic [5:0] st;
        logic       idle;
    } exp_t;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_lowpower_seq #(.ADDR_W(AW), .CTL_W(CW), .NUM_EXT(NE), .NUM_CHIP(NC)) u_dut (
        .clk(clk), .rst_n(rst_n), .halt_exec(halt_exec), .sleep_exec(sleep_exec),
        .io_stop(io_stop), .ctl_stop_a(ctl_stop_a), .ctl_stop_b(ctl_stop_b),
        .gie(gie), .nmi_req(nmi_req), .ext_irq(ext_irq), .ext_irq_en(ext_irq_en),
        .onchip_irq(onchip_irq), .onchip_irq_en(onchip_irq_en), .bus_grant(bus_grant),
        .core_addr(core_addr), .core_ctl(core_ctl), .addr_out(addr_out), .ctl_out(ctl_out),
        .cpu_clk_en(cpu_clk_en), .dma_clk_en(dma_clk_en), .refresh_en(refresh_en),
        .halt_n(halt_n), .resume_pulse(resume_pulse), .take_irq_pulse(take_irq_pulse)
    );

    // driver side: expectation for the outputs after the coming rising edge
    task automatic expect_next(input string tag, input logic [5:0] st, input logic idle);
        exp_t e;
        e.tag  = tag;
        e.st   = st;
        e.idle = idle;
        q.push_back(e);
    endtask

    task automatic clear_inputs();
        halt_exec = 1'b0; sleep_exec = 1'b0;
        io_stop = 1'b0; ctl_stop_a = 1'b0; ctl_stop_b = 1'b0;
        gie = 1'b0; nmi_req = 1'b0; bus_grant = 1'b0;
        ext_irq = '0; ext_irq_en = '0; onchip_irq = '0; onchip_irq_en = '0;
    endtask

    // monitor: a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (q.size() > 0) begin
                exp_t e;
                logic [5:0]    act;
                logic [AW-1:0] ea;
                logic [CW-1:0] ec;
                e   = q.pop_front();
                act = {cpu_clk_en, dma_clk_en, refresh_en, halt_n, resume_pulse, take_irq_pulse};
                ea  = e.idle ? {AW{1'b1}} : core_addr;
                ec  = e.idle ? {CW{1'b1}} : core_ctl;
                checks++;
                if (act !== e.st) begin
                    errors++;
                    $display("FAIL %s status act=%b exp=%b", e.tag, act, e.st);
                end
                checks++;
                if (addr_out !== ea || ctl_out !== ec) begin
                    errors++;
                    $display("FAIL %s bus act=%h/%b exp=%h/%b", e.tag, addr_out, ctl_out, ea, ec);
                end
            end
        end
    end

    task automatic enter_sleep();
        @(negedge clk); clear_inputs(); sleep_exec = 1'b1; expect_next("R2 enter", V_SLP, 1'b1);
        @(negedge clk); sleep_exec = 1'b0;                 expect_next("R2 hold", V_SLP, 1'b1);
    endtask

    task automatic enter_halt();
        @(negedge clk); clear_inputs(); halt_exec = 1'b1; expect_next("R4 enter", V_HLT, 1'b0);
        @(negedge clk); halt_exec = 1'b0;                 expect_next("R4 hold", V_HLT, 1'b0);
    endtask

    initial begin
        clear_inputs();
        @(negedge clk); rst_n = 1'b0; expect_next("R1 reset", V_RUN, 1'b0);
        @(negedge clk); rst_n = 1'b1; expect_next("R1 run", V_RUN, 1'b0);

        // R3: each qualifier bit blocks sleep on its own
        @(negedge clk); sleep_exec = 1'b1; io_stop = 1'b1;    expect_next("R3 io_stop", V_RUN, 1'b0);
        @(negedge clk); clear_inputs(); sleep_exec = 1'b1; ctl_stop_a = 1'b1; expect_next("R3 ctl_a", V_RUN, 1'b0);
        @(negedge clk); clear_inputs(); sleep_exec = 1'b1; ctl_stop_b = 1'b1; expect_next("R3 ctl_b", V_RUN, 1'b0);
        @(negedge clk); clear_inputs(); expect_next("R3 still run", V_RUN, 1'b0);

        // R2, R5: sleep with bus parking and grant
        enter_sleep();
        @(negedge clk); bus_grant = 1'b1; expect_next("R5 granted", V_SLP, 1'b0);
        @(negedge clk); bus_grant = 1'b0; core_addr = 20'h0F0F0; expect_next("R5 parked", V_SLP, 1'b1);

        // R6: disabled requests ignored in sleep
        @(negedge clk); ext_irq = 3'b111; onchip_irq = 8'hFF; gie = 1'b1; expect_next("R6 sleep disabled", V_SLP, 1'b1);
        @(negedge clk); expect_next("R6 sleep disabled 2", V_SLP, 1'b1);

        // R8: enabled external, gie 0 -> resume
        @(negedge clk); clear_inputs(); ext_irq = 3'b010; ext_irq_en = 3'b010; expect_next("R8 resume", V_RES, 1'b0);
        @(negedge clk); clear_inputs(); expect_next("R11 back to run", V_RUN, 1'b0);

        // R7: enabled on-chip, gie 1 -> interrupt
        enter_sleep();
        @(negedge clk); onchip_irq = 8'h02; onchip_irq_en = 8'h02; gie = 1'b1; expect_next("R7 take irq", V_IRQ, 1'b0);
        @(negedge clk); expect_next("R11 one cycle", V_RUN, 1'b0);

        // R9: NMI from sleep regardless of gie
        enter_sleep();
        @(negedge clk); nmi_req = 1'b1; expect_next("R9 nmi sleep", V_IRQ, 1'b0);
        @(negedge clk); clear_inputs(); expect_next("R11 after nmi", V_RUN, 1'b0);

        // R4, R6, R10: halt behaviour
        enter_halt();
        @(negedge clk); ext_irq = 3'b100; ext_irq_en = 3'b100; expect_next("R10 gie0 stays", V_HLT, 1'b0);
        @(negedge clk); clear_inputs(); onchip_irq = 8'h80; gie = 1'b1; expect_next("R6 halt disabled", V_HLT, 1'b0);
        @(negedge clk); onchip_irq_en = 8'h80; expect_next("R10 halt irq", V_IRQ, 1'b0);
        @(negedge clk); clear_inputs(); expect_next("R11 halt exit", V_RUN, 1'b0);
        enter_halt();
        @(negedge clk); nmi_req = 1'b1; expect_next("R9 nmi halt", V_IRQ, 1'b0);
        @(negedge clk); clear_inputs(); expect_next("R9 run", V_RUN, 1'b0);

        // R1: reset in the middle of sleep
        enter_sleep();
        @(negedge clk); rst_n = 1'b0; expect_next("R1 reset sleep", V_RUN, 1'b0);
        @(negedge clk); rst_n = 1'b1; expect_next("R1 after reset", V_RUN, 1'b0);

        // R4: precedence between simultaneous pulses
        @(negedge clk); sleep_exec = 1'b1; halt_exec = 1'b1; expect_next("R4 sleep wins", V_SLP, 1'b1);
        @(negedge clk); clear_inputs(); rst_n = 1'b0; expect_next("R1 clear", V_RUN, 1'b0);
        @(negedge clk); rst_n = 1'b1; sleep_exec = 1'b1; halt_exec = 1'b1; io_stop = 1'b1;
        expect_next("R4 halt when blocked", V_HLT, 1'b0);
        @(negedge clk); clear_inputs(); expect_next("R4 halt hold", V_HLT, 1'b0);

        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule